// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Layer with Two-Winner Selection

This block runs one layer of leaky integrate-and-fire neurons over a binary input image, one neuron and one input at a time. The image is loaded as a set of 32-bit words while the layer is idle. A start pulse then runs a chosen number of timesteps. Each timestep walks a fixed order of phases: integrate, fire, winner select, a learn slot, and, once the image is finished, homeostasis.

While it integrates, the layer fetches every synaptic weight through a read port with one cycle of latency and sums the weights of the active pixels. It leaks each membrane potential and adds that sum. A neuron whose potential rises above its own threshold spikes, drops to zero and sits out a fixed number of timesteps. After each fire phase the block reports at most two winners, with a strobe and a valid flag for each. Per-neuron spike counts are exported continuously.

Every fixed number of images, the thresholds of neurons that won are raised by one step and the thresholds of all the others are lowered by one step, inside a configured window. No single neuron can then keep every response. The weight memory and any learning rule live outside the block; the learn phase is a one-cycle slot for them.

Top module: `lif_k2_layer`

## Requirements
- R1: Pixel p of the image is bit p%32 of word p/32. A word write is accepted only while `busy` is low and only for a word address below ceil(N_INPUTS/32). Any other write leaves the stored image unchanged.
- R2: For each neuron n and each input i in ascending order, the block raises `wt_rd` and drives `wt_addr` = n*N_INPUTS+i. It uses `wt_data` from the following cycle. Reads happen only while `busy` is high, and one timestep makes exactly N_NEURONS*N_INPUTS reads.
- R3: A neuron that is not refractory updates its potential each timestep as v - (v>>4) plus the sum of the weights of its active pixels. The result saturates at 2^POT_W-1.
- R4: A non-refractory neuron whose potential is strictly greater than its threshold spikes in the fire phase. Its potential becomes 0 and its spike count rises by 1, saturating at 2^CNT_W-1.
- R5: After a spike the neuron neither integrates nor spikes for the next 4 timesteps, and it integrates again on the 5th.
- R6: Once per timestep `win_valid` pulses for one cycle. `win0` is the spiking neuron with the largest pre-spike potential and `win1` is the next largest. Equal potentials go to the lower index, and a flag is low when fewer neurons spiked.
- R7: After every 64th completed image (HOMEO_PERIOD), each neuron that won in any timestep of those images has its threshold raised by 1, up to `th_max`. Every other neuron has its threshold lowered by 1, down to `th_min`.
- R8: A start clears all potentials, refractory timers and spike counts. Thresholds carry over from earlier images.
- R9: After reset the outputs are all low, the spike counts are zero, and every threshold equals `th_init`.
- R10: `start` is sampled only while idle and runs `num_steps` timesteps, with 0 treated as 1. `img_done` then pulses for one cycle and `busy` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_we | input | 1 | Image word write strobe |
| img_waddr | input | WA_W | Image word address |
| img_wdata | input | WORD_W | Image word, one bit per pixel |
| start | input | 1 | Begin processing the stored image |
| num_steps | input | STEP_W | Timesteps per image, sampled at start |
| th_init | input | POT_W | Threshold loaded at reset |
| th_min | input | POT_W | Lower threshold bound |
| th_max | input | POT_W | Upper threshold bound |
| wt_rd | output | 1 | Weight read strobe |
| wt_addr | output | ADDR_W | Weight address, neuron*N_INPUTS+input |
| wt_data | input | WEIGHT_W | Weight returned one cycle after the read |
| busy | output | 1 | An image is being processed |
| win_valid | output | 1 | End-of-timestep winner strobe |
| win0_ok | output | 1 | First winner present |
| win0_idx | output | NN_W | First winner index |
| win1_ok | output | 1 | Second winner present |
| win1_idx | output | NN_W | Second winner index |
| img_done | output | 1 | Image finished pulse |
| spike_cnt | output | N_NEURONS*CNT_W | Per-neuron spike counts, neuron n at bits n*CNT_W |

## Verification
The bench runs a four-neuron, 64-input configuration in which neurons 2 and 3 share every weight. Their potentials are always equal, so a design that broke ties toward the higher index would report 3 ahead of 2. All-ones images drive the potential past its 13-bit ceiling; wrapping instead of clamping would drop the potential below threshold and lose spikes. Runs of up to ten timesteps place spikes exactly five steps apart, so an off-by-one refractory timer shifts every later winner. Writes issued while busy or above the last word must not change the image. A narrow threshold window is pushed against both bounds by repeated homeostasis, so an unclamped or mistimed update changes which neurons fire.

// File: rtl/lif_pkg.sv
package lif_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INTEG,
    PH_DRAIN,
    PH_FIRE,
    PH_SELECT,
    PH_LEARN,
    PH_HOMEO,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/lif_pixel_buf.sv
module lif_pixel_buf #(
  parameter int N_INPUTS = 784,
  parameter int WORD_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [$clog2((N_INPUTS+WORD_W-1)/WORD_W+1)-1:0] waddr,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [$clog2(N_INPUTS)-1:0] rd_idx,
  output logic                        rd_bit
);
  localparam int N_WORDS = (N_INPUTS + WORD_W - 1) / WORD_W;
  localparam int WA_W    = $clog2(N_WORDS + 1);
  localparam int NI_W    = $clog2(N_INPUTS);
  localparam int BIT_W   = $clog2(WORD_W);

  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) words[w] <= '0;
      else if (we && waddr == WA_W'(w)) words[w] <= wdata;
    end
  end

  logic [WORD_W-1:0] sel_word;
  assign sel_word = words[rd_idx[NI_W-1:BIT_W]];
  assign rd_bit   = sel_word[rd_idx[BIT_W-1:0]];
endmodule

// File: rtl/lif_top2.sv
module lif_top2 #(
  parameter int N_NEURONS = 16,
  parameter int KEY_W     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic offer,
  input  logic [(N_NEURONS>1?$clog2(N_NEURONS):1)-1:0] offer_idx,
  input  logic [KEY_W-1:0] offer_key,
  output logic w0_ok,
  output logic [(N_NEURONS>1?$clog2(N_NEURONS):1)-1:0] w0_idx,
  output logic w1_ok,
  output logic [(N_NEURONS>1?$clog2(N_NEURONS):1)-1:0] w1_idx
);
  logic [KEY_W-1:0] k0, k1;

  // Candidates arrive in ascending index order; a strict compare keeps the
  // earlier (lower) index on equal keys.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      w0_ok  <= 1'b0;
      w1_ok  <= 1'b0;
      w0_idx <= '0;
      w1_idx <= '0;
      k0     <= '0;
      k1     <= '0;
    end else if (offer) begin
      if (!w0_ok || offer_key > k0) begin
        w1_ok  <= w0_ok;
        w1_idx <= w0_idx;
        k1     <= k0;
        w0_ok  <= 1'b1;
        w0_idx <= offer_idx;
        k0     <= offer_key;
      end else if (!w1_ok || offer_key > k1) begin
        w1_ok  <= 1'b1;
        w1_idx <= offer_idx;
        k1     <= offer_key;
      end
    end
  end
endmodule

// File: rtl/lif_homeostasis.sv
module lif_homeostasis #(
  parameter int N_NEURONS = 16,
  parameter int TH_W      = 16,
  parameter int PERIOD    = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TH_W-1:0]      th_init,
  input  logic [TH_W-1:0]      th_min,
  input  logic [TH_W-1:0]      th_max,
  input  logic                 mark,
  input  logic [N_NEURONS-1:0] mark_vec,
  input  logic                 img_end,
  input  logic [(N_NEURONS>1?$clog2(N_NEURONS):1)-1:0] rd_idx,
  output logic [TH_W-1:0]      rd_th
);
  localparam int PC_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [TH_W-1:0]      th [N_NEURONS];
  logic [N_NEURONS-1:0] won;
  logic [PC_W-1:0]      img_cnt;
  logic                 apply;

  assign apply = img_end && (img_cnt == PC_W'(PERIOD - 1));
  assign rd_th = th[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      img_cnt <= '0;
      won     <= '0;
    end else begin
      if (img_end) img_cnt <= apply ? '0 : img_cnt + PC_W'(1);
      if (apply) won <= '0;
      else if (mark) won <= won | mark_vec;
    end
  end

  for (genvar g = 0; g < N_NEURONS; g++) begin : g_th
    always_ff @(posedge clk) begin
      if (rst) th[g] <= th_init;
      else if (apply) begin
        if (won[g]) begin
          if (th[g] < th_max) th[g] <= th[g] + TH_W'(1);
        end else begin
          if (th[g] > th_min) th[g] <= th[g] - TH_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lif_k2_layer.sv
module lif_k2_layer
  import lif_pkg::*;
#(
  parameter int N_NEURONS    = 16,
  parameter int N_INPUTS     = 784,
  parameter int WORD_W       = 32,
  parameter int WEIGHT_W     = 8,
  parameter int POT_W        = 16,
  parameter int CNT_W        = 8,
  parameter int STEP_W       = 8,
  parameter int REFRACT      = 4,
  parameter int LEAK_SHIFT   = 4,
  parameter int HOMEO_PERIOD = 64,
  localparam int N_WORDS = (N_INPUTS + WORD_W - 1) / WORD_W,
  localparam int WA_W    = $clog2(N_WORDS + 1),
  localparam int NN_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1,
  localparam int ADDR_W  = $clog2(N_NEURONS * N_INPUTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       img_we,
  input  logic [WA_W-1:0]            img_waddr,
  input  logic [WORD_W-1:0]          img_wdata,
  input  logic                       start,
  input  logic [STEP_W-1:0]          num_steps,
  input  logic [POT_W-1:0]           th_init,
  input  logic [POT_W-1:0]           th_min,
  input  logic [POT_W-1:0]           th_max,
  output logic                       wt_rd,
  output logic [ADDR_W-1:0]          wt_addr,
  input  logic [WEIGHT_W-1:0]        wt_data,
  output logic                       busy,
  output logic                       win_valid,
  output logic                       win0_ok,
  output logic [NN_W-1:0]            win0_idx,
  output logic                       win1_ok,
  output logic [NN_W-1:0]            win1_idx,
  output logic                       img_done,
  output logic [N_NEURONS*CNT_W-1:0] spike_cnt
);
  localparam int NI_W    = $clog2(N_INPUTS);
  localparam int ACC_W   = WEIGHT_W + $clog2(N_INPUTS + 1);
  localparam int EXT_W   = ((POT_W > ACC_W) ? POT_W : ACC_W) + 1;
  localparam int RF_W    = $clog2(REFRACT + 1);
  localparam logic [POT_W-1:0] POT_MAX = {POT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  phase_t phase;

  logic [POT_W-1:0]  pot  [N_NEURONS];
  logic [RF_W-1:0]   refr [N_NEURONS];
  logic [CNT_W-1:0]  cnt  [N_NEURONS];

  logic [NN_W-1:0]   sc_n, fn;
  logic [NI_W-1:0]   sc_i;
  logic [STEP_W-1:0] step_q, steps_m1;

  // two-stage sideband pipeline matching the external read latency
  logic              p1_valid, p1_first, p1_last, p1_pix;
  logic [NN_W-1:0]   p1_n;
  logic              p2_valid, p2_first, p2_last, p2_pix;
  logic [NN_W-1:0]   p2_n;
  logic [ACC_W-1:0]  acc, acc_sum;
  logic [EXT_W-1:0]  pot_ext;
  logic [POT_W-1:0]  pot_next;

  logic              pix_bit;
  logic [POT_W-1:0]  th_cur;
  logic              spike_now;
  logic              t2_w0_ok, t2_w1_ok;
  logic [NN_W-1:0]   t2_w0_idx, t2_w1_idx;
  logic [N_NEURONS-1:0] mark_vec;

  assign busy = (phase != PH_IDLE);

  lif_pixel_buf #(.N_INPUTS(N_INPUTS), .WORD_W(WORD_W)) u_pix (
    .clk   (clk),
    .rst   (rst),
    .we    (img_we && phase == PH_IDLE),
    .waddr (img_waddr),
    .wdata (img_wdata),
    .rd_idx(sc_i),
    .rd_bit(pix_bit)
  );

  lif_homeostasis #(.N_NEURONS(N_NEURONS), .TH_W(POT_W), .PERIOD(HOMEO_PERIOD)) u_homeo (
    .clk     (clk),
    .rst     (rst),
    .th_init (th_init),
    .th_min  (th_min),
    .th_max  (th_max),
    .mark    (phase == PH_SELECT),
    .mark_vec(mark_vec),
    .img_end (phase == PH_HOMEO),
    .rd_idx  (fn),
    .rd_th   (th_cur)
  );

  assign spike_now = (phase == PH_FIRE) && (refr[fn] == '0) && (pot[fn] > th_cur);

  lif_top2 #(.N_NEURONS(N_NEURONS), .KEY_W(POT_W)) u_top2 (
    .clk      (clk),
    .rst      (rst),
    .clr      (phase == PH_SELECT),
    .offer    (spike_now),
    .offer_idx(fn),
    .offer_key(pot[fn]),
    .w0_ok    (t2_w0_ok),
    .w0_idx   (t2_w0_idx),
    .w1_ok    (t2_w1_ok),
    .w1_idx   (t2_w1_idx)
  );

  always_comb begin
    mark_vec = '0;
    if (t2_w0_ok) mark_vec[t2_w0_idx] = 1'b1;
    if (t2_w1_ok) mark_vec[t2_w1_idx] = 1'b1;
  end

  always_comb begin
    acc_sum  = (p2_first ? '0 : acc) + (p2_pix ? ACC_W'(wt_data) : '0);
    pot_ext  = EXT_W'(pot[p2_n]) - EXT_W'(pot[p2_n] >> LEAK_SHIFT) + EXT_W'(acc_sum);
    pot_next = (pot_ext > EXT_W'(POT_MAX)) ? POT_MAX : pot_ext[POT_W-1:0];
  end

  for (genvar g = 0; g < N_NEURONS; g++) begin : g_cnt_out
    assign spike_cnt[g*CNT_W +: CNT_W] = cnt[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      sc_n      <= '0;
      sc_i      <= '0;
      fn        <= '0;
      step_q    <= '0;
      steps_m1  <= '0;
      p1_valid  <= 1'b0;
      p1_first  <= 1'b0;
      p1_last   <= 1'b0;
      p1_pix    <= 1'b0;
      p1_n      <= '0;
      p2_valid  <= 1'b0;
      p2_first  <= 1'b0;
      p2_last   <= 1'b0;
      p2_pix    <= 1'b0;
      p2_n      <= '0;
      acc       <= '0;
      wt_rd     <= 1'b0;
      wt_addr   <= '0;
      win_valid <= 1'b0;
      win0_ok   <= 1'b0;
      win0_idx  <= '0;
      win1_ok   <= 1'b0;
      win1_idx  <= '0;
      img_done  <= 1'b0;
      for (int n = 0; n < N_NEURONS; n++) begin
        pot[n]  <= '0;
        refr[n] <= '0;
        cnt[n]  <= '0;
      end
    end else begin
      win_valid <= 1'b0;
      win0_ok   <= 1'b0;
      win1_ok   <= 1'b0;
      img_done  <= 1'b0;
      wt_rd     <= 1'b0;
      p1_valid  <= 1'b0;

      p2_valid <= p1_valid;
      p2_first <= p1_first;
      p2_last  <= p1_last;
      p2_pix   <= p1_pix;
      p2_n     <= p1_n;

      if (p2_valid) begin
        acc <= acc_sum;
        if (p2_last && refr[p2_n] == '0) pot[p2_n] <= pot_next;
      end

      case (phase)
        PH_IDLE: begin
          if (start) begin
            for (int n = 0; n < N_NEURONS; n++) begin
              pot[n]  <= '0;
              refr[n] <= '0;
              cnt[n]  <= '0;
            end
            step_q   <= '0;
            steps_m1 <= (num_steps == '0) ? '0 : num_steps - STEP_W'(1);
            sc_n     <= '0;
            sc_i     <= '0;
            phase    <= PH_INTEG;
          end
        end
        PH_INTEG: begin
          wt_rd    <= 1'b1;
          wt_addr  <= ADDR_W'(sc_n) * ADDR_W'(N_INPUTS) + ADDR_W'(sc_i);
          p1_valid <= 1'b1;
          p1_n     <= sc_n;
          p1_first <= (sc_i == '0);
          p1_last  <= (sc_i == NI_W'(N_INPUTS - 1));
          p1_pix   <= pix_bit;
          if (sc_i == NI_W'(N_INPUTS - 1)) begin
            sc_i <= '0;
            if (sc_n == NN_W'(N_NEURONS - 1)) begin
              sc_n  <= '0;
              phase <= PH_DRAIN;
            end else begin
              sc_n <= sc_n + NN_W'(1);
            end
          end else begin
            sc_i <= sc_i + NI_W'(1);
          end
        end
        PH_DRAIN: begin
          if (!p1_valid && !p2_valid) begin
            fn    <= '0;
            phase <= PH_FIRE;
          end
        end
        PH_FIRE: begin
          if (refr[fn] != '0) begin
            refr[fn] <= refr[fn] - RF_W'(1);
          end else if (spike_now) begin
            pot[fn]  <= '0;
            refr[fn] <= RF_W'(REFRACT);
            if (cnt[fn] != CNT_MAX) cnt[fn] <= cnt[fn] + CNT_W'(1);
          end
          if (fn == NN_W'(N_NEURONS - 1)) phase <= PH_SELECT;
          else fn <= fn + NN_W'(1);
        end
        PH_SELECT: begin
          win_valid <= 1'b1;
          win0_ok   <= t2_w0_ok;
          win0_idx  <= t2_w0_idx;
          win1_ok   <= t2_w1_ok;
          win1_idx  <= t2_w1_idx;
          phase     <= PH_LEARN;
        end
        PH_LEARN: begin
          if (step_q == steps_m1) begin
            phase <= PH_HOMEO;
          end else begin
            step_q <= step_q + STEP_W'(1);
            phase  <= PH_INTEG;
          end
        end
        PH_HOMEO: phase <= PH_DONE;
        PH_DONE: begin
          img_done <= 1'b1;
          phase    <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lif_k2_layer_chk.sv
module lif_k2_layer_chk #(
  parameter int N_NEURONS = 16,
  parameter int N_INPUTS  = 784
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic wt_rd,
  input logic [$clog2(N_NEURONS*N_INPUTS)-1:0] wt_addr,
  input logic win_valid,
  input logic win0_ok,
  input logic [(N_NEURONS>1?$clog2(N_NEURONS):1)-1:0] win0_idx,
  input logic win1_ok,
  input logic [(N_NEURONS>1?$clog2(N_NEURONS):1)-1:0] win1_idx,
  input logic img_done
);
  localparam int ADDR_W = $clog2(N_NEURONS * N_INPUTS);

  assert_fetch_busy_R2: assert property (@(posedge clk) disable iff (rst)
    wt_rd |-> busy);

  assert_addr_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (wt_rd && $past(wt_rd)) |-> (wt_addr == $past(wt_addr) + ADDR_W'(1)));

  assert_win_order_R6: assert property (@(posedge clk) disable iff (rst)
    win1_ok |-> win0_ok);

  assert_win_distinct_R6: assert property (@(posedge clk) disable iff (rst)
    win1_ok |-> (win0_idx != win1_idx));

  assert_flags_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    win0_ok |-> win_valid);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> !win_valid);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    img_done |-> (!busy && !win_valid));
endmodule

bind lif_k2_layer lif_k2_layer_chk #(.N_NEURONS(N_NEURONS), .N_INPUTS(N_INPUTS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .wt_rd    (wt_rd),
  .wt_addr  (wt_addr),
  .win_valid(win_valid),
  .win0_ok  (win0_ok),
  .win0_idx (win0_idx),
  .win1_ok  (win1_ok),
  .win1_idx (win1_idx),
  .img_done (img_done)
);

// File: tb/sim_lif_k2_layer.sv
`timescale 1ns/1ps
module sim_lif_k2_layer;
  localparam int NN = 4;
  localparam int NI = 64;
  localparam int PW = 13;
  localparam int CW = 8;
  localparam int HP = 4;
  localparam int NWORDS = 2;
  localparam int PMAX = (1 << PW) - 1;
  localparam int TH0 = 4000;
  localparam int THMIN = 3998;
  localparam int THMAX = 4001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic img_we = 1'b0;
  logic [1:0] img_waddr = '0;
  logic [31:0] img_wdata = '0;
  logic start = 1'b0;
  logic [7:0] num_steps = 8'd1;
  logic wt_rd;
  logic [7:0] wt_addr;
  logic [7:0] wt_data = '0;
  logic busy, win_valid, win0_ok, win1_ok, img_done;
  logic [1:0] win0_idx, win1_idx;
  logic [NN*CW-1:0] spike_cnt;

  always #2 clk = ~clk;

  lif_k2_layer #(
    .N_NEURONS(NN), .N_INPUTS(NI), .WORD_W(32), .WEIGHT_W(8), .POT_W(PW),
    .CNT_W(CW), .STEP_W(8), .REFRACT(4), .LEAK_SHIFT(4), .HOMEO_PERIOD(HP)
  ) u0 (
    .clk(clk), .rst(rst), .img_we(img_we), .img_waddr(img_waddr), .img_wdata(img_wdata),
    .start(start), .num_steps(num_steps),
    .th_init(PW'(TH0)), .th_min(PW'(THMIN)), .th_max(PW'(THMAX)),
    .wt_rd(wt_rd), .wt_addr(wt_addr), .wt_data(wt_data), .busy(busy),
    .win_valid(win_valid), .win0_ok(win0_ok), .win0_idx(win0_idx),
    .win1_ok(win1_ok), .win1_idx(win1_idx), .img_done(img_done), .spike_cnt(spike_cnt)
  );

  // neurons 2 and 3 share weights so their potentials tie
  function automatic int wfun(input int a);
    int n, i, m;
    n = a / NI;
    i = a % NI;
    m = (n == 3) ? 2 : n;
    return (m * 71 + i * 37 + ((i * i) % 13) * 5 + 11) % 256;
  endfunction

  int fetch_cnt = 0;
  always @(posedge clk) begin
    if (wt_rd) begin
      wt_data   <= 8'(wfun(int'(wt_addr)));
      fetch_cnt <= fetch_cnt + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference state
  logic [31:0] mimg [NWORDS];
  int mv [NN];
  int mr [NN];
  int mc [NN];
  int mth [NN];
  int mwon [NN];
  int mimgs = 0;
  int homeo_done = 0;

  task automatic wr_word(input int a, input logic [31:0] d, input bit take);
    @(negedge clk);
    img_we    = 1'b1;
    img_waddr = 2'(a);
    img_wdata = d;
    @(negedge clk);
    img_we = 1'b0;
    if (take && a < NWORDS) mimg[a] = d;
  endtask

  function automatic int act_sum(input int n);
    int s = 0;
    for (int i = 0; i < NI; i++)
      if (mimg[i / 32][i % 32]) s += wfun(n * NI + i);
    return s;
  endfunction

  task automatic run_image(input int steps, input bit inject, input string wtag);
    int f0, eff, b0, b1, k0, k1;
    bit b0ok, b1ok, got, early;
    string ctag;
    f0  = fetch_cnt;
    eff = (steps == 0) ? 1 : steps;
    @(negedge clk);
    start     = 1'b1;
    num_steps = 8'(steps);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < NN; n++) begin mv[n] = 0; mr[n] = 0; mc[n] = 0; end
    if (inject) begin
      // ignored: busy-time write and start
      img_we = 1'b1; img_waddr = 2'd0; img_wdata = 32'hFFFF_FFFF; start = 1'b1; num_steps = 8'd9;
      @(negedge clk);
      img_we = 1'b0; start = 1'b0;
    end
    early = 1'b0;
    for (int s = 0; s < eff; s++) begin
      for (int n = 0; n < NN; n++) begin
        if (mr[n] == 0) begin
          int x;
          x = mv[n] - (mv[n] >> 4) + act_sum(n);
          mv[n] = (x > PMAX) ? PMAX : x;
        end
      end
      b0ok = 0; b1ok = 0; b0 = 0; b1 = 0; k0 = 0; k1 = 0;
      for (int n = 0; n < NN; n++) begin
        if (mr[n] > 0) mr[n]--;
        else if (mv[n] > mth[n]) begin
          if (!b0ok || mv[n] > k0) begin
            b1ok = b0ok; b1 = b0; k1 = k0; b0ok = 1; b0 = n; k0 = mv[n];
          end else if (!b1ok || mv[n] > k1) begin
            b1ok = 1; b1 = n; k1 = mv[n];
          end
          mv[n] = 0; mr[n] = 4;
          if (mc[n] < 255) mc[n]++;
        end
      end
      if (b0ok) mwon[b0] = 1;
      if (b1ok) mwon[b1] = 1;
      got = 0;
      while (!got && !early) begin
        @(negedge clk);
        if (img_done) early = 1;
        if (win_valid) got = 1;
      end
      chk(got, "R10 step strobe", int'(got), 1);
      chk(win0_ok == b0ok, {wtag, " R6 win0_ok"}, int'(win0_ok), int'(b0ok));
      chk(win1_ok == b1ok, {wtag, " R6 win1_ok"}, int'(win1_ok), int'(b1ok));
      if (b0ok) chk(int'(win0_idx) == b0, {wtag, " R6 win0_idx"}, int'(win0_idx), b0);
      if (b1ok) chk(int'(win1_idx) == b1, {wtag, " R6 win1_idx R5"}, int'(win1_idx), b1);
    end
    got = early;
    while (!got) begin
      @(negedge clk);
      if (win_valid) begin chk(0, "R10 extra step", 1, 0); end
      if (img_done) got = 1;
    end
    chk(!busy, "R10 busy at done", int'(busy), 0);
    ctag = (homeo_done > 0) ? "R7 R4 R5 R8 count" : "R4 R5 R8 count";
    for (int n = 0; n < NN; n++)
      chk(int'(spike_cnt[n*CW +: CW]) == mc[n], ctag, int'(spike_cnt[n*CW +: CW]), mc[n]);
    chk(fetch_cnt - f0 == eff * NN * NI, "R2 fetch count", fetch_cnt - f0, eff * NN * NI);
    mimgs++;
    if (mimgs == HP) begin
      mimgs = 0;
      homeo_done++;
      for (int n = 0; n < NN; n++) begin
        if (mwon[n] != 0) begin if (mth[n] < THMAX) mth[n]++; end
        else begin if (mth[n] > THMIN) mth[n]--; end
        mwon[n] = 0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int n = 0; n < NN; n++) begin mth[n] = TH0; mwon[n] = 0; end
    for (int w = 0; w < NWORDS; w++) mimg[w] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !win_valid && !img_done && !wt_rd, "R9 reset outputs", int'(busy), 0);
    chk(spike_cnt == '0, "R9 reset counts", int'(spike_cnt), 0);

    // all zero image: nothing spikes
    run_image(6, 1'b0, "R3");
    // all ones: saturation, refractory spacing, ties between 2 and 3
    wr_word(0, 32'hFFFF_FFFF, 1'b1);
    wr_word(1, 32'hFFFF_FFFF, 1'b1);
    run_image(10, 1'b0, "R3 R5");
    wr_word(0, 32'h5555_5555, 1'b1);
    wr_word(1, 32'hAAAA_AAAA, 1'b1);
    run_image(7, 1'b0, "R3");
    wr_word(0, 32'h0000_0001, 1'b1);
    wr_word(1, 32'h0000_0000, 1'b1);
    run_image(0, 1'b0, "R10");
    for (int k = 0; k < 12; k++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (k % 3 == 1) begin a = a | $urandom(); b = b | $urandom(); end
      if (k == 2) begin
        // image write while busy and start while busy are ignored
        wr_word(0, a, 1'b1);
        wr_word(1, b, 1'b1);
        run_image(5, 1'b1, "R10");
        continue;
      end
      if (k == 3) begin
        // keep word 0; word 2 is beyond the image
        wr_word(2, 32'hFFFF_FFFF, 1'b0);
        wr_word(1, b, 1'b1);
        run_image(6, 1'b0, "R1");
        continue;
      end
      wr_word(0, a, 1'b1);
      wr_word(1, b, 1'b1);
      run_image(1 + (k * 7) % 10, 1'b0, (homeo_done > 0) ? "R7 R3" : "R3");
    end
    // repeated all-ones images push thresholds against the bounds
    wr_word(0, 32'hFFFF_FFFF, 1'b1);
    wr_word(1, 32'hFFFF_FFFF, 1'b1);
    for (int k = 0; k < 4; k++) run_image(4, 1'b0, "R7");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule